// File: doc/BRIEF.md
# Decimal and ASCII Accumulator Adjust Unit

This unit applies the decimal correction steps that follow binary arithmetic on an 8-bit accumulator byte and its companion high byte. It offers six operations. Two repair packed two-digit BCD after an add or a subtract. Two repair unpacked single-digit values after an add or a subtract, and these carry into or borrow from the high byte. The last two split a byte into quotient and remainder by a programmable base, or fold a high and low digit back into one byte.

The operation code, both bytes, the incoming carry and auxiliary-carry flags and the base are sampled on each rising clock edge. The new bytes and the flag set carry, auxiliary carry, zero, parity and sign appear on the registered outputs one cycle later. A new operation can be issued every cycle. The unit has no fault path, so a base of zero must not be issued to the split operation.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge.
- R2: The outputs after a rising edge with `rst` low are the function of the inputs sampled at that edge. The latency is exactly one cycle.
- R3: Op code 0 (packed add adjust). Let L be `lo_in` and "low fix" be (L[3:0] > 9 or `aux_in`). A low fix adds 6 to L modulo 256 and sets aux out. Then, if L > 0x99 or `carry_in` is set, 0x60 is added modulo 256 and carry out is set. Otherwise the carry and aux outputs are 0.
- R4: Op code 1 (packed subtract adjust). The low fix subtracts 6 modulo 256 and sets aux out. When L < 6 it also sets carry out. Then, if L > 0x99 or `carry_in` is set, 0x60 is subtracted modulo 256 and carry out is set.
- R5: Op code 2 (unpacked add adjust) with low fix true: `lo_out` = (L+6) & 0x0F. `hi_out` = `hi_in` + 1, plus 1 more if L > 0xF9, modulo 256. Carry out and aux out are both 1.
- R6: Op code 3 (unpacked subtract adjust) with low fix true: `lo_out` = (L−6) & 0x0F. `hi_out` = `hi_in` − 1, minus 1 more if L < 6, modulo 256. Carry out and aux out are both 1.
- R7: Op codes 2 and 3 with low fix false: `lo_out` = L & 0x0F, `hi_out` = `hi_in`, and carry out and aux out are 0.
- R8: Op code 4 (split by base) with `base_in` ≠ 0: `hi_out` = L / base and `lo_out` = L mod base. Carry out and aux out are 0.
- R9: Op code 5 (fold by base): `lo_out` = (`hi_in` × base + L) mod 256 and `hi_out` = 0. Carry out and aux out are 0.
- R10: For every op code, zero out = (`lo_out` == 0), parity out = 1 exactly when `lo_out` has an even number of one bits, and sign out = `lo_out`[7].
- R11: Op codes 0 and 1 leave the high byte unchanged: `hi_out` = `hi_in`.
- R12: Op codes 6 and 7 pass both bytes through unchanged, with carry out and aux out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_in | input | 3 | Operation code 0..7 |
| lo_in | input | 8 | Accumulator low byte |
| hi_in | input | 8 | Companion high byte |
| carry_in | input | 1 | Incoming carry flag |
| aux_in | input | 1 | Incoming auxiliary-carry flag |
| base_in | input | 8 | Base for op codes 4 and 5 |
| lo_out | output | 8 | Adjusted low byte |
| hi_out | output | 8 | Adjusted high byte |
| carry_out | output | 1 | Carry flag result |
| aux_out | output | 1 | Auxiliary-carry flag result |
| zero_out | output | 1 | Low byte equals zero |
| parity_out | output | 1 | Even number of ones in low byte |
| sign_out | output | 1 | Bit 7 of low byte |

## Verification
For the four adjust operations, the bench sweeps every low byte against all four combinations of the incoming flags. This separates the low-nibble path, the >0x99 path and the flag-forced paths from one another. It also exposes the borrow-dependent carry of the packed subtract and the extra step into the high byte near 0xFA and below 6. The split operation runs every low byte against every nonzero base, which exercises each quotient and remainder boundary. The fold operation runs every low byte against a grid of high bytes and bases that forces 8-bit wraparound. The reserved codes run with mixed bytes to show pure pass-through.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 3;

    localparam logic [NIB_W-1:0]  NIB_LIMIT  = NIB_W'(9);
    localparam logic [BYTE_W-1:0] BYTE_LIMIT = BYTE_W'(8'h99);
    localparam logic [BYTE_W-1:0] LOW_FIX    = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_FIX   = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] WRAP_EDGE  = BYTE_W'(8'hF9);

    typedef enum logic [OP_W-1:0] {
        OP_PACK_ADD = 3'd0,
        OP_PACK_SUB = 3'd1,
        OP_UNP_ADD  = 3'd2,
        OP_UNP_SUB  = 3'd3,
        OP_SPLIT    = 3'd4,
        OP_FOLD     = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              cy;
        logic              ax;
    } adj_res_t;

    typedef struct packed {
        logic zf;
        logic pf;
        logic sf;
    } adj_flags_t;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic adj_flags_t result_flags(input logic [BYTE_W-1:0] v);
        adj_flags_t f;
        f.zf = (v == '0);
        f.pf = even_ones(v);
        f.sf = v[BYTE_W-1];
        return f;
    endfunction

endpackage

// File: rtl/bcd_packed_adj.sv
module bcd_packed_adj
    import bcd_adj_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              cy_i,
    input  logic              ax_i,
    output adj_res_t          res_o
);
    logic              low_fix;
    logic              high_fix;
    logic              low_borrow;
    logic [BYTE_W-1:0] step1;
    logic [BYTE_W-1:0] step2;

    assign low_fix    = (lo_i[NIB_W-1:0] > NIB_LIMIT) | ax_i;
    assign high_fix   = (lo_i > BYTE_LIMIT) | cy_i;
    assign low_borrow = (lo_i < LOW_FIX);

    generate
        if (SUBTRACT) begin : g_sub
            assign step1 = low_fix  ? (lo_i - LOW_FIX)   : lo_i;
            assign step2 = high_fix ? (step1 - HIGH_FIX) : step1;
            assign res_o.cy = high_fix | (low_fix & low_borrow);
        end else begin : g_add
            assign step1 = low_fix  ? (lo_i + LOW_FIX)   : lo_i;
            assign step2 = high_fix ? (step1 + HIGH_FIX) : step1;
            assign res_o.cy = high_fix | (1'b0 & low_borrow);
        end
    endgenerate

    assign res_o.lo = step2;
    assign res_o.hi = hi_i;
    assign res_o.ax = low_fix;

endmodule

// File: rtl/bcd_unpacked_adj.sv
module bcd_unpacked_adj
    import bcd_adj_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              ax_i,
    output adj_res_t          res_o
);
    logic              adjust;
    logic              extra;
    logic [BYTE_W-1:0] lo_moved;
    logic [BYTE_W-1:0] hi_moved;

    assign adjust = (lo_i[NIB_W-1:0] > NIB_LIMIT) | ax_i;

    generate
        if (SUBTRACT) begin : g_sub
            assign extra    = (lo_i < LOW_FIX);
            assign lo_moved = lo_i - LOW_FIX;
            assign hi_moved = hi_i - BYTE_W'(1) - BYTE_W'(extra);
        end else begin : g_add
            assign extra    = (lo_i > WRAP_EDGE);
            assign lo_moved = lo_i + LOW_FIX;
            assign hi_moved = hi_i + BYTE_W'(1) + BYTE_W'(extra);
        end
    endgenerate

    always_comb begin
        res_o.lo = '0;
        if (adjust) begin
            res_o.lo[NIB_W-1:0] = lo_moved[NIB_W-1:0];
            res_o.hi            = hi_moved;
        end else begin
            res_o.lo[NIB_W-1:0] = lo_i[NIB_W-1:0];
            res_o.hi            = hi_i;
        end
        res_o.cy = adjust;
        res_o.ax = adjust;
    end

endmodule

// File: rtl/bcd_base_adj.sv
module bcd_base_adj
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] base_i,
    output adj_res_t          split_o,
    output adj_res_t          fold_o
);
    logic [BYTE_W-1:0] rem_chain [0:BYTE_W];
    logic [BYTE_W-1:0] quot;

    assign rem_chain[0] = '0;

    generate
        for (genvar g = 0; g < BYTE_W; g++) begin : g_stage
            logic [BYTE_W:0] shifted;
            logic            fits;
            assign shifted = {rem_chain[g], lo_i[BYTE_W-1-g]};
            assign fits    = (shifted >= {1'b0, base_i});
            assign quot[BYTE_W-1-g] = fits;
            assign rem_chain[g+1] = fits ? BYTE_W'(shifted - {1'b0, base_i})
                                         : shifted[BYTE_W-1:0];
        end
    endgenerate

    assign split_o.lo = rem_chain[BYTE_W];
    assign split_o.hi = quot;
    assign split_o.cy = 1'b0;
    assign split_o.ax = 1'b0;

    assign fold_o.lo = hi_i * base_i + lo_i;
    assign fold_o.hi = '0;
    assign fold_o.cy = 1'b0;
    assign fold_o.ax = 1'b0;

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_in,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic              carry_in,
    input  logic              aux_in,
    input  logic [BYTE_W-1:0] base_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out,
    output logic              carry_out,
    output logic              aux_out,
    output logic              zero_out,
    output logic              parity_out,
    output logic              sign_out
);
    adj_res_t   r_padd, r_psub, r_uadd, r_usub, r_split, r_fold, r_pass, r_sel;
    adj_flags_t f_sel;
    adj_op_e    op;

    assign op = adj_op_e'(op_in);

    bcd_packed_adj #(.SUBTRACT(1'b0)) u_pack_add (
        .lo_i(lo_in), .hi_i(hi_in), .cy_i(carry_in), .ax_i(aux_in), .res_o(r_padd));
    bcd_packed_adj #(.SUBTRACT(1'b1)) u_pack_sub (
        .lo_i(lo_in), .hi_i(hi_in), .cy_i(carry_in), .ax_i(aux_in), .res_o(r_psub));
    bcd_unpacked_adj #(.SUBTRACT(1'b0)) u_unp_add (
        .lo_i(lo_in), .hi_i(hi_in), .ax_i(aux_in), .res_o(r_uadd));
    bcd_unpacked_adj #(.SUBTRACT(1'b1)) u_unp_sub (
        .lo_i(lo_in), .hi_i(hi_in), .ax_i(aux_in), .res_o(r_usub));
    bcd_base_adj u_base (
        .lo_i(lo_in), .hi_i(hi_in), .base_i(base_in),
        .split_o(r_split), .fold_o(r_fold));

    assign r_pass = '{lo: lo_in, hi: hi_in, cy: 1'b0, ax: 1'b0};

    always_comb begin
        unique case (op)
            OP_PACK_ADD: r_sel = r_padd;
            OP_PACK_SUB: r_sel = r_psub;
            OP_UNP_ADD:  r_sel = r_uadd;
            OP_UNP_SUB:  r_sel = r_usub;
            OP_SPLIT:    r_sel = r_split;
            OP_FOLD:     r_sel = r_fold;
            default:     r_sel = r_pass;
        endcase
    end

    assign f_sel = result_flags(r_sel.lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_out     <= '0;
            hi_out     <= '0;
            carry_out  <= 1'b0;
            aux_out    <= 1'b0;
            zero_out   <= 1'b0;
            parity_out <= 1'b0;
            sign_out   <= 1'b0;
        end else begin
            lo_out     <= r_sel.lo;
            hi_out     <= r_sel.hi;
            carry_out  <= r_sel.cy;
            aux_out    <= r_sel.ax;
            zero_out   <= f_sel.zf;
            parity_out <= f_sel.pf;
            sign_out   <= f_sel.sf;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (lo_out == '0 && hi_out == '0 && !carry_out && !aux_out)); // R1

    AST_SPLIT_RECOMPOSE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == OP_SPLIT && $past(base_in) != '0)
        |-> ((16'(hi_out) * 16'($past(base_in)) + 16'(lo_out)) == 16'($past(lo_in)))); // R8

    AST_SPLIT_REM_BELOW_BASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == OP_SPLIT && $past(base_in) != '0)
        |-> (lo_out < $past(base_in))); // R8

    AST_UNP_HIGH_NIBBLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_in) == OP_UNP_ADD || $past(op_in) == OP_UNP_SUB))
        |-> (lo_out[BYTE_W-1:NIB_W] == '0 && carry_out == aux_out)); // R7

    AST_PACKED_HI_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_in) == OP_PACK_ADD || $past(op_in) == OP_PACK_SUB))
        |-> (hi_out == $past(hi_in))); // R11

    AST_PACKED_CARRY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_in) == OP_PACK_ADD || $past(op_in) == OP_PACK_SUB)
         && $past(carry_in)) |-> carry_out); // R4

    AST_FOLD_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_in) == OP_FOLD)
        |-> (hi_out == '0 && !carry_out && !aux_out)); // R9

    AST_FLAGS_TRACK_LOW: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sign_out == lo_out[BYTE_W-1] && zero_out == (lo_out == '0))); // R10

endmodule

// File: tb/bcd_adjust_unit_bench.sv
module bcd_adjust_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_in = '0;
    logic [7:0] lo_in = '0, hi_in = '0, base_in = '0;
    logic       carry_in = 1'b0, aux_in = 1'b0;
    logic [7:0] lo_out, hi_out;
    logic       carry_out, aux_out, zero_out, parity_out, sign_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bcd_adjust_unit u_bcd_adjust_unit (
        .clk(clk), .rst(rst), .op_in(op_in), .lo_in(lo_in), .hi_in(hi_in),
        .carry_in(carry_in), .aux_in(aux_in), .base_in(base_in),
        .lo_out(lo_out), .hi_out(hi_out), .carry_out(carry_out), .aux_out(aux_out),
        .zero_out(zero_out), .parity_out(parity_out), .sign_out(sign_out));

    // packed result: {lo, hi, cy, ax, zf, pf, sf}
    function automatic logic [22:0] model(input int op, input int l, input int h,
                                          input int c, input int a, input int b);
        int lo_r, hi_r, cy, ax, ones;
        lo_r = l; hi_r = h; cy = 0; ax = 0;
        case (op)
            0: begin
                if ((l % 16) > 9 || a != 0) begin lo_r = (lo_r + 6) % 256; ax = 1; end
                if (l > 153 || c != 0) begin lo_r = (lo_r + 96) % 256; cy = 1; end
            end
            1: begin
                if ((l % 16) > 9 || a != 0) begin
                    ax = 1;
                    if (l < 6 || c != 0) cy = 1;
                    lo_r = (lo_r + 250) % 256;
                end
                if (l > 153 || c != 0) begin lo_r = (lo_r + 160) % 256; cy = 1; end
            end
            2, 3: begin
                if ((l % 16) > 9 || a != 0) begin
                    cy = 1; ax = 1;
                    if (op == 2) begin
                        lo_r = (l + 6) % 16;
                        hi_r = (h + 1 + ((l > 249) ? 1 : 0)) % 256;
                    end else begin
                        lo_r = (l + 250) % 16;
                        hi_r = (h + 256 - 1 - ((l < 6) ? 1 : 0)) % 256;
                    end
                end else begin
                    lo_r = l % 16;
                end
            end
            4: begin hi_r = l / b; lo_r = l % b; end
            5: begin lo_r = (h * b + l) % 256; hi_r = 0; end
            default: ;
        endcase
        ones = 0;
        for (int k = 0; k < 8; k++) ones += (lo_r >> k) & 1;
        return {lo_r[7:0], hi_r[7:0], cy[0], ax[0], (lo_r == 0),
                ((ones % 2) == 0), lo_r[7]};
    endfunction

    task automatic check(input string tag, input logic [22:0] exp);
        logic [22:0] act;
        act = {lo_out, hi_out, carry_out, aux_out, zero_out, parity_out, sign_out};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d lo=%h hi=%h c=%0d a=%0d base=%0d actual=%h expected=%h",
                     tag, op_in, lo_in, hi_in, carry_in, aux_in, base_in, act, exp);
        end
    endtask

    // drive away from the edge, one registered stage, sample after the edge
    task automatic run(input string tag, input int op, input int l, input int h,
                       input int c, input int a, input int b);
        @(negedge clk);
        op_in = 3'(op); lo_in = 8'(l); hi_in = 8'(h);
        carry_in = c[0]; aux_in = a[0]; base_in = 8'(b);
        @(posedge clk);
        #1;
        check(tag, model(op, l, h, c, a, b));
    endtask

    initial begin
        int hs[4];
        int bs[5];
        hs = '{8'h00, 8'h35, 8'h7F, 8'hFF};
        bs = '{1, 10, 16, 37, 255};
        op_in = 3'd2; lo_in = 8'hFF; hi_in = 8'hAA; carry_in = 1'b1; aux_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 23'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: one-cycle latency, each op shown with fresh inputs every cycle
        for (int l = 0; l < 256; l++)
            for (int f = 0; f < 4; f++) begin
                run("R3 R2 R10 packed add", 0, l, 8'h5A, f & 1, f >> 1, 0);
                run("R4 R11 packed sub", 1, l, 8'hC3, f & 1, f >> 1, 0);
            end
        for (int l = 0; l < 256; l++)
            for (int f = 0; f < 4; f++)
                for (int hi = 0; hi < 4; hi++) begin
                    run("R5 R7 unpacked add", 2, l, hs[hi], f & 1, f >> 1, 0);
                    run("R6 R7 unpacked sub", 3, l, hs[hi], f & 1, f >> 1, 0);
                end
        for (int b = 1; b < 256; b++)
            for (int l = 0; l < 256; l++)
                run("R8 R10 split", 4, l, (l * 7) % 256, b & 1, (b >> 1) & 1, b);
        for (int l = 0; l < 256; l++)
            for (int h = 0; h < 256; h += 17)
                for (int bi = 0; bi < 5; bi++)
                    run("R9 R10 fold", 5, l, h, l & 1, h & 1, bs[bi]);
        for (int l = 0; l < 256; l += 3) begin
            run("R12 reserved 6", 6, l, 255 - l, 1, 1, l);
            run("R12 reserved 7", 7, l, (l * 5) % 256, 1, 0, 3);
        end

        // R1 again: reset mid-run wipes a nonzero result
        run("R2 before reset", 2, 8'h3F, 8'h10, 0, 1, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 23'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule